// File: doc/BRIEF.md
# ECAM Configuration Address Translator

This block sits on the outbound side of a PCIe root port. It turns memory-mapped accesses that land in a 256 MiB configuration window into configuration request headers. Bus, device and function come straight from fixed address bits of the window. They are never reprogrammed into a region before each access. Software sets up a window base and a small set of translation regions. Each region has a base, a limit, a type code and a control word.

Each accepted access takes one of three paths. An access to the first 1 MiB slice of the window (the root bus) goes to a local register port. An access that falls inside an enabled region becomes a Type 0 or Type 1 configuration read or write, with one DWORD of data. Any other access gets an immediate error response with all-ones read data. Requests enter through a valid/ready port and are held in a single output slot until the chosen destination takes them.

Top module: `ecam_cfg_xlate`

## Requirements
- R1: After reset, `cfg_valid`, `loc_valid`, `err_valid` and `win_err` are low, `req_ready` is high, the window base is zero and every region is disabled.
- R2: A translated access yields bus = addr[27:20], device = addr[19:15], function = addr[14:12] and register number = addr[11:2]. The byte enables, the write data and the read/write flag pass through unchanged.
- R3: A region matches only when its control bit 31 (enable) and bit 28 (shift mode) are both set, its type code is 4 or 5, and base <= addr <= limit (inclusive, full 32-bit compare). Other control bits have no effect.
- R4: A region with type code 4 produces Type 0 requests (`cfg_type1` = 0) and one with type code 5 produces Type 1 requests (`cfg_type1` = 1). Any other type code makes the region never match.
- R5: When several regions match, the one with the lowest index supplies the translation.
- R6: An access whose addr[31:28] equals the window base bits [31:28] and whose addr[27:20] is zero is never translated. It appears on the local port with `loc_addr` = addr[19:0], even when a region covers it.
- R7: An access that is outside the window, or that is in the window but outside the root slice and matched by no region, produces a one-cycle `err_valid` with `err_rdata` all ones. No configuration or local request is issued.
- R8: Writing a window base whose bits [27:0] are not all zero sets `win_err`. While `win_err` is set, every access takes the error path. Writing an aligned base clears `win_err`.
- R9: An output slot that is not taken keeps all its fields unchanged and holds `req_ready` low. A new request is accepted in the same cycle that the slot empties.
- R10: Register address bit 5 selects the window base register. Otherwise bits [4:2] give the region index and bits [1:0] the field (0 base, 1 limit, 2 type in wdata[4:0], 3 control). Writes to a region index at or above the region count change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (window select, region index, field) |
| reg_wdata | input | 32 | Register write data |
| win_err | output | 1 | Window base is not 256 MiB aligned |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted this cycle |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Access byte enables |
| req_wdata | input | 32 | Access write data |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration request taken |
| cfg_write | output | 1 | 1 = configuration write, 0 = read |
| cfg_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 10 | DWORD register number |
| cfg_be | output | 4 | First-DWORD byte enables |
| cfg_wdata | output | 32 | Write payload |
| loc_valid | output | 1 | Local (root bus) access valid |
| loc_ready | input | 1 | Local access taken |
| loc_write | output | 1 | Local access direction |
| loc_addr | output | 20 | Offset within the root slice |
| loc_be | output | 4 | Local byte enables |
| loc_wdata | output | 32 | Local write data |
| err_valid | output | 1 | Error response pulse |
| err_rdata | output | 32 | All ones while `err_valid` is high |

## Verification
A corrupted region register stays invisible until the next access that lands in or near that region. That access then shows the wrong `cfg_type1`, the wrong path, or a spurious error one cycle after acceptance. A stuck output slot shows as `req_ready` staying low, or as a phantom valid on the cycle after the slot should have emptied. A wrong alignment flag shows on `win_err` one cycle after the base write, and on the path of the next access. For this reason the reference model is compared against every output on every cycle, not only when a transfer completes.

// File: rtl/ecam_xlate_pkg.sv
package ecam_xlate_pkg;

    // Control word bit positions that the region matcher decodes
    localparam int CTRL_EN_BIT    = 31;
    localparam int CTRL_SHIFT_BIT = 28;

    // Region type codes
    localparam logic [4:0] RTYPE_CFG0 = 5'h04;
    localparam logic [4:0] RTYPE_CFG1 = 5'h05;

    // Register field selectors
    localparam logic [1:0] FLD_BASE  = 2'd0;
    localparam logic [1:0] FLD_LIMIT = 2'd1;
    localparam logic [1:0] FLD_TYPE  = 2'd2;
    localparam logic [1:0] FLD_CTRL  = 2'd3;

    // Address slicing of the configuration window
    localparam int WIN_LSB  = 28;
    localparam int BUS_LSB  = 20;
    localparam int BUS_W    = 8;
    localparam int DEV_LSB  = 15;
    localparam int DEV_W    = 5;
    localparam int FN_LSB   = 12;
    localparam int FN_W     = 3;
    localparam int REGN_LSB = 2;
    localparam int REGN_W   = 10;
    localparam int TAG_W    = 32 - WIN_LSB;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_CFG  = 2'd1,
        SLOT_LOC  = 2'd2,
        SLOT_ERR  = 2'd3
    } slot_kind_e;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        logic [4:0]  rtype;
        logic        en;
        logic        shift;
    } region_t;

    typedef struct packed {
        slot_kind_e          kind;
        logic                type1;
        logic                write;
        logic [WIN_LSB-1:0]  addr;
        logic [3:0]          be;
        logic [31:0]         data;
    } slot_t;

endpackage

// File: rtl/ecam_region_regs.sv
module ecam_region_regs
    import ecam_xlate_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int RIDX_W      = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [RIDX_W+2:0]             waddr,
    input  logic [31:0]                   wdata,
    output region_t [NUM_REGIONS-1:0]     regions,
    output logic [TAG_W-1:0]              win_tag,
    output logic                          win_err
);

    localparam int WSEL_BIT = RIDX_W + 2;

    typedef struct packed {
        region_t [NUM_REGIONS-1:0] rgn;
        logic [TAG_W-1:0]          tag;
        logic                      werr;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [RIDX_W-1:0] widx;
    logic [1:0]        wfld;

    assign widx = waddr[RIDX_W+1:2];
    assign wfld = waddr[1:0];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (waddr[WSEL_BIT]) begin
                regs_d.tag  = wdata[31:WIN_LSB];
                regs_d.werr = |wdata[WIN_LSB-1:0];
            end else begin
                for (int i = 0; i < NUM_REGIONS; i++) begin
                    if (widx == RIDX_W'(i)) begin
                        case (wfld)
                            FLD_BASE:  regs_d.rgn[i].base  = wdata;
                            FLD_LIMIT: regs_d.rgn[i].limit = wdata;
                            FLD_TYPE:  regs_d.rgn[i].rtype = wdata[4:0];
                            default: begin
                                regs_d.rgn[i].en    = wdata[CTRL_EN_BIT];
                                regs_d.rgn[i].shift = wdata[CTRL_SHIFT_BIT];
                            end
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regions = regs_q.rgn;
    assign win_tag = regs_q.tag;
    assign win_err = regs_q.werr;

endmodule

// File: rtl/ecam_window_match.sv
module ecam_window_match
    import ecam_xlate_pkg::*;
#(
    parameter int NUM_REGIONS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  region_t [NUM_REGIONS-1:0] regions,
    input  logic [TAG_W-1:0]          win_tag,
    input  logic                      win_err,
    input  logic [31:0]               addr,
    output logic                      in_root,
    output logic                      hit,
    output logic                      hit_type1,
    output logic [NUM_REGIONS-1:0]    grant
);

    logic                   in_win;
    logic [NUM_REGIONS-1:0] cand;

    assign in_win  = !win_err && (addr[31:WIN_LSB] == win_tag);
    assign in_root = in_win && (addr[WIN_LSB-1:BUS_LSB] == '0);

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
            logic type_ok;
            logic in_range;
            assign type_ok  = (regions[g].rtype == RTYPE_CFG0) ||
                              (regions[g].rtype == RTYPE_CFG1);
            assign in_range = (addr >= regions[g].base) && (addr <= regions[g].limit);
            assign cand[g]  = in_win && regions[g].en && regions[g].shift &&
                              type_ok && in_range;
        end
    endgenerate

    // Lowest index wins
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        hit_type1 = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (cand[i] && !found) begin
                found     = 1'b1;
                grant[i]  = 1'b1;
                hit_type1 = (regions[i].rtype == RTYPE_CFG1);
            end
        end
    end

    assign hit = (|grant) && !in_root;

    p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_unaligned_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |-> (!hit && !in_root));

endmodule

// File: rtl/ecam_out_slot.sv
module ecam_out_slot
    import ecam_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [WIN_LSB-1:0]  req_addr,
    input  logic [3:0]          req_be,
    input  logic [31:0]         req_wdata,
    input  logic                dec_root,
    input  logic                dec_hit,
    input  logic                dec_type1,
    input  logic                cfg_ready,
    input  logic                loc_ready,
    output logic                req_ready,
    output slot_t               slot
);

    slot_t slot_d, slot_q;
    logic  drain;

    always_comb begin
        drain = ((slot_q.kind == SLOT_CFG) && cfg_ready) ||
                ((slot_q.kind == SLOT_LOC) && loc_ready) ||
                (slot_q.kind == SLOT_ERR);
        req_ready = (slot_q.kind == SLOT_IDLE) || drain;

        slot_d = slot_q;
        if (drain) begin
            slot_d.kind = SLOT_IDLE;
        end
        if (req_valid && req_ready) begin
            if (dec_root) begin
                slot_d.kind = SLOT_LOC;
            end else if (dec_hit) begin
                slot_d.kind = SLOT_CFG;
            end else begin
                slot_d.kind = SLOT_ERR;
            end
            slot_d.type1 = dec_type1;
            slot_d.write = req_write;
            slot_d.addr  = req_addr;
            slot_d.be    = req_be;
            slot_d.data  = req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot = slot_q;

    p_root_goes_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_root) |=> (slot_q.kind == SLOT_LOC));

    p_miss_goes_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !dec_root && !dec_hit) |=> (slot_q.kind == SLOT_ERR));

    p_hold_while_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q.kind == SLOT_CFG) && !cfg_ready) |=> ((slot_q.kind == SLOT_CFG) && $stable(slot_q)));

    p_block_while_local_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q.kind == SLOT_LOC) && !loc_ready) |-> !req_ready);

endmodule

// File: rtl/ecam_cfg_xlate.sv
module ecam_cfg_xlate
    import ecam_xlate_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int RIDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W+2:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              win_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic              cfg_write,
    output logic              cfg_type1,
    output logic [7:0]        cfg_bus,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_fn,
    output logic [9:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    output logic              loc_valid,
    input  logic              loc_ready,
    output logic              loc_write,
    output logic [19:0]       loc_addr,
    output logic [3:0]        loc_be,
    output logic [31:0]       loc_wdata,
    output logic              err_valid,
    output logic [31:0]       err_rdata
);

    region_t [NUM_REGIONS-1:0] regions;
    logic [TAG_W-1:0]          win_tag;
    logic                      dec_root;
    logic                      dec_hit;
    logic                      dec_type1;
    logic [NUM_REGIONS-1:0]    dec_grant;
    slot_t                     slot;

    ecam_region_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .RIDX_W      (RIDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (reg_addr),
        .wdata   (reg_wdata),
        .regions (regions),
        .win_tag (win_tag),
        .win_err (win_err)
    );

    ecam_window_match #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .regions   (regions),
        .win_tag   (win_tag),
        .win_err   (win_err),
        .addr      (req_addr),
        .in_root   (dec_root),
        .hit       (dec_hit),
        .hit_type1 (dec_type1),
        .grant     (dec_grant)
    );

    ecam_out_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr[WIN_LSB-1:0]),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .dec_root  (dec_root),
        .dec_hit   (dec_hit),
        .dec_type1 (dec_type1),
        .cfg_ready (cfg_ready),
        .loc_ready (loc_ready),
        .req_ready (req_ready),
        .slot      (slot)
    );

    assign cfg_valid = (slot.kind == SLOT_CFG);
    assign cfg_write = slot.write;
    assign cfg_type1 = slot.type1;
    assign cfg_bus   = slot.addr[BUS_LSB +: BUS_W];
    assign cfg_dev   = slot.addr[DEV_LSB +: DEV_W];
    assign cfg_fn    = slot.addr[FN_LSB +: FN_W];
    assign cfg_reg   = slot.addr[REGN_LSB +: REGN_W];
    assign cfg_be    = slot.be;
    assign cfg_wdata = slot.data;

    assign loc_valid = (slot.kind == SLOT_LOC);
    assign loc_write = slot.write;
    assign loc_addr  = slot.addr[BUS_LSB-1:0];
    assign loc_be    = slot.be;
    assign loc_wdata = slot.data;

    assign err_valid = (slot.kind == SLOT_ERR);
    assign err_rdata = {32{err_valid}};

endmodule

// File: tb/tb_ecam_cfg_xlate.sv
module tb_ecam_cfg_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        win_err;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_valid, cfg_write, cfg_type1;
    logic        cfg_ready = 1'b1;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [9:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        loc_valid, loc_write;
    logic        loc_ready = 1'b1;
    logic [19:0] loc_addr;
    logic [3:0]  loc_be;
    logic [31:0] loc_wdata;
    logic        err_valid;
    logic [31:0] err_rdata;

    always #10 clk = ~clk;

    ecam_cfg_xlate dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 0;

    // Reference model state
    int          m_kind = 0;   // 0 idle, 1 cfg, 2 local, 3 error
    logic        m_t1 = 0, m_w = 0;
    logic [31:0] m_addr = 0, m_d = 0;
    logic [3:0]  m_be = 0;
    logic [31:0] mb[2], ml[2];
    logic [4:0]  mt[2];
    logic        me[2], ms[2];
    logic [31:0] mwin = 0;
    logic        mwerr = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_ready();
        return (m_kind == 0) || (m_kind == 1 && cfg_ready) ||
               (m_kind == 2 && loc_ready) || (m_kind == 3);
    endfunction

    function automatic void decode(input logic [31:0] a, output int k, output logic t1);
        k = 3; t1 = 0;
        if (!mwerr && a[31:28] == mwin[31:28]) begin
            if (a[27:20] == 0) k = 2;
            else begin
                for (int i = 0; i < 2; i++) begin
                    if (k == 3 && me[i] && ms[i] && (mt[i] == 5'd4 || mt[i] == 5'd5) &&
                        a >= mb[i] && a <= ml[i]) begin
                        k = 1; t1 = (mt[i] == 5'd5);
                    end
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_kind = 0; mwin = 0; mwerr = 0;
            for (int i = 0; i < 2; i++) begin
                mb[i] = 0; ml[i] = 0; mt[i] = 0; me[i] = 0; ms[i] = 0;
            end
        end else begin
            int  k;
            logic t1;
            logic acc;
            acc = req_valid && m_ready();
            if ((m_kind == 1 && cfg_ready) || (m_kind == 2 && loc_ready) || m_kind == 3)
                m_kind = 0;
            if (acc) begin
                decode(req_addr, k, t1);
                m_kind = k; m_t1 = t1; m_addr = req_addr;
                m_w = req_write; m_be = req_be; m_d = req_wdata;
            end
            if (reg_we) begin
                if (reg_addr[5]) begin
                    mwin = reg_wdata; mwerr = (reg_wdata[27:0] != 0);
                end else if (reg_addr[4:2] < 3'd2) begin
                    case (reg_addr[1:0])
                        2'd0: mb[reg_addr[2]] = reg_wdata;
                        2'd1: ml[reg_addr[2]] = reg_wdata;
                        2'd2: mt[reg_addr[2]] = reg_wdata[4:0];
                        default: begin
                            me[reg_addr[2]] = reg_wdata[31];
                            ms[reg_addr[2]] = reg_wdata[28];
                        end
                    endcase
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R9 req_ready", 32'(req_ready), 32'(m_ready()));
            chk("R3/R5 cfg_valid", 32'(cfg_valid), 32'(m_kind == 1));
            chk("R6 loc_valid", 32'(loc_valid), 32'(m_kind == 2));
            chk("R7 err_valid", 32'(err_valid), 32'(m_kind == 3));
            chk("R8 win_err", 32'(win_err), 32'(mwerr));
            if (m_kind == 1) begin
                chk("R2 cfg_bus", 32'(cfg_bus), 32'(m_addr[27:20]));
                chk("R2 cfg_dev", 32'(cfg_dev), 32'(m_addr[19:15]));
                chk("R2 cfg_fn", 32'(cfg_fn), 32'(m_addr[14:12]));
                chk("R2 cfg_reg", 32'(cfg_reg), 32'(m_addr[11:2]));
                chk("R2 cfg_be", 32'(cfg_be), 32'(m_be));
                chk("R2 cfg_wdata", cfg_wdata, m_d);
                chk("R2 cfg_write", 32'(cfg_write), 32'(m_w));
                chk("R4 cfg_type1", 32'(cfg_type1), 32'(m_t1));
            end
            if (m_kind == 2) begin
                chk("R6 loc_addr", 32'(loc_addr), 32'(m_addr[19:0]));
                chk("R6 loc_be", 32'(loc_be), 32'(m_be));
                chk("R6 loc_wdata", loc_wdata, m_d);
                chk("R6 loc_write", 32'(loc_write), 32'(m_w));
            end
            if (m_kind == 3) chk("R7 err_rdata", err_rdata, 32'hFFFF_FFFF);
        end
    end

    task automatic wr_reg(input logic win, input logic [2:0] idx, input logic [1:0] fld,
                          input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = {win, idx, fld}; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input logic w, input logic [3:0] be,
                        input logic [31:0] d);
        @(posedge clk); #2;
        req_valid = 1'b1; req_addr = a; req_write = w; req_be = be; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) begin
                @(posedge clk); #2;
                req_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 valids idle", 32'({cfg_valid, loc_valid, err_valid}), 32'h0);
        chk("R1 ready high", 32'(req_ready), 32'h1);
        chk("R1 win_err low", 32'(win_err), 32'h0);

        // R1: zero window base, no regions: root slice local, others error
        send(32'h0000_0040, 1'b0, 4'hF, 32'h0);
        send(32'h0010_0000, 1'b0, 4'hF, 32'h0);

        // Program window and two regions (R10 layout)
        wr_reg(1'b1, 3'd0, 2'd0, 32'h3000_0000);
        wr_reg(1'b0, 3'd0, 2'd0, 32'h3010_0000);
        wr_reg(1'b0, 3'd0, 2'd1, 32'h301F_FFFF);
        wr_reg(1'b0, 3'd0, 2'd2, 32'h0000_0004);
        wr_reg(1'b0, 3'd0, 2'd3, 32'h9000_0000);
        wr_reg(1'b0, 3'd1, 2'd0, 32'h3020_0000);
        wr_reg(1'b0, 3'd1, 2'd1, 32'h30FF_FFFF);
        wr_reg(1'b0, 3'd1, 2'd2, 32'h0000_0005);
        wr_reg(1'b0, 3'd1, 2'd3, 32'hD048_0000);   // R3: extra ctrl bits ignored

        // R6 root, R2/R4 type 0 and type 1, R3 limit boundaries, R7 misses
        send(32'h3000_0104, 1'b1, 4'hF, 32'hCAFE_0001);
        send(32'h3018_A7FC, 1'b0, 4'h3, 32'h0);
        send(32'h305F_F004, 1'b1, 4'hC, 32'h1234_5678);
        send(32'h30FF_FFFC, 1'b0, 4'hF, 32'h0);
        send(32'h3020_0000, 1'b1, 4'h1, 32'hA5A5_5A5A);
        send(32'h3100_0000, 1'b0, 4'hF, 32'h0);
        send(32'h2FFF_FFFC, 1'b0, 4'hF, 32'h0);

        // R9: stalled configuration output and stalled local output
        @(posedge clk); #2; cfg_ready = 1'b0;
        send(32'h3011_2344, 1'b1, 4'h6, 32'h0BAD_F00D);
        fork begin repeat (6) @(posedge clk); #2; cfg_ready = 1'b1; end join_none
        send(32'h3033_3008, 1'b0, 4'hF, 32'h0);
        @(posedge clk); #2; loc_ready = 1'b0;
        send(32'h3000_0FF0, 1'b1, 4'h8, 32'h7777_1111);
        fork begin repeat (4) @(posedge clk); #2; loc_ready = 1'b1; end join_none
        send(32'h3012_0000, 1'b0, 4'hF, 32'h0);

        // R4: unsupported type code never matches
        wr_reg(1'b0, 3'd1, 2'd2, 32'h0000_0006);
        send(32'h3050_0000, 1'b0, 4'hF, 32'h0);
        wr_reg(1'b0, 3'd1, 2'd2, 32'h0000_0005);

        // R5: overlapping regions, lowest index wins
        wr_reg(1'b0, 3'd1, 2'd0, 32'h3010_0000);
        send(32'h3018_0000, 1'b0, 4'hF, 32'h0);
        // R3: shift mode off, then enable off, region 0 drops out
        wr_reg(1'b0, 3'd0, 2'd3, 32'h8000_0000);
        send(32'h3018_0000, 1'b0, 4'hF, 32'h0);
        wr_reg(1'b0, 3'd0, 2'd3, 32'h1000_0000);
        send(32'h3018_0004, 1'b1, 4'hF, 32'h4444_0000);
        // R6: a region covering the root slice does not capture it
        wr_reg(1'b0, 3'd1, 2'd0, 32'h3000_0000);
        send(32'h3000_8000, 1'b0, 4'hF, 32'h0);
        wr_reg(1'b0, 3'd1, 2'd0, 32'h3010_0000);

        // R10: writes to missing region index 2 must not alias region 0
        wr_reg(1'b0, 3'd0, 2'd3, 32'h9000_0000);
        wr_reg(1'b0, 3'd2, 2'd3, 32'h0000_0000);
        wr_reg(1'b0, 3'd2, 2'd2, 32'h0000_0005);
        send(32'h3018_0000, 1'b0, 4'hF, 32'h0);

        // R8: unaligned window base flagged, everything errors
        wr_reg(1'b1, 3'd0, 2'd0, 32'h3800_0000);
        send(32'h3000_0010, 1'b0, 4'hF, 32'h0);
        send(32'h3018_0000, 1'b0, 4'hF, 32'h0);
        send(32'h3800_0010, 1'b0, 4'hF, 32'h0);
        wr_reg(1'b1, 3'd0, 2'd0, 32'h3000_0000);
        send(32'h3000_0010, 1'b1, 4'hF, 32'h5555_AAAA);
        send(32'h3018_0000, 1'b0, 4'hF, 32'h0);

        repeat (4) @(posedge clk);
        @(negedge clk);
        fin = 1;
        summary();
        $finish;
    end

endmodule